// File: doc/BRIEF.md
# Supply-Monitor Interrupt Controller

This block is the digital side of a low-supply interrupt monitor. Software programs a threshold code and an enable bit through a small 32-bit register bus. The block drives the code to an external analog comparator and samples the comparator's "supply below threshold" output through a synchronizer. When the block is enabled it waits a programmable settling period with monitoring off, then reports readiness. From then on a new below-threshold indication latches a sticky interrupt flag, and the flag drives the interrupt request.

The control register is guarded by an unlock key. Any other value written to the key register restores protection. Software clears the flag by writing 0 to the clear bit. The flag stays cleared while the supply remains low, and it sets again only on a fresh below-threshold event. The settling count advances only while the peripheral clock enable is high, which models the low-power modes.

Top module: `svmon_top`

## Requirements
- R1: After reset the control register is locked, and control writes are ignored. Writing 0x1ACCE553 to the key register (offset 0x0C) unlocks it. Writing any other value to the key register locks it again.
- R2: The control register is at offset 0x00 and resets to 0x40. Bit 7 is the enable, bits 5:2 are the threshold code (also driven on `thr_sel`), bit 6 always reads 1 and bits 1:0 always read 0.
- R3: While unlocked, a control write carrying a threshold code other than 0,1,2,3,4,7,8,9 leaves the control register unchanged.
- R4: While the enable bit is 0, the interrupt flag never sets, whatever the comparator shows.
- R5: An accepted write that sets the enable restarts settling. The ready flag (bit 0 of the ready register, offset 0x10) reads 1 exactly STAB_CYC counted cycles after the write edge, and reads 0 before that.
- R6: An accepted write that changes the threshold code while enabled clears ready at once and restarts settling. Rewriting the same code and enable leaves ready set.
- R7: While enabled and ready, a rising below-threshold indication sets the sticky flag. The flag shows at bit 7 of the status register (offset 0x04, other bits 0) and on `irq`.
- R8: A write to the clear register (offset 0x08) with bit 0 = 0 clears the flag, and the flag stays clear while the comparator stays low. Writing bit 0 = 1 has no effect.
- R9: While `pclk_en` is 0, the settling count does not advance.
- R10: Reads of the key register and of unmapped offsets return 0.
- R11: An accepted write with enable 0 clears ready in the same cycle.
- R12: A comparator rise reaches `irq` on the third clock edge after it appears, through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pclk_en | input | 1 | Peripheral clock enable; settling counts only while high |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cmp_below | input | 1 | Asynchronous comparator output, 1 when the supply is below threshold |
| thr_sel | output | 4 | Threshold code to the comparator |
| irq | output | 1 | Interrupt request (the sticky flag) |

## Verification
The assertions assume that write strobes last one cycle, with the address and data stable around the sampling edge. They also assume the comparator input changes slowly compared with the clock, so the synchronizer sees clean levels. The bench drives every input on the falling edge, issues single-cycle writes through one task, and holds comparator levels for several cycles. The bench then checks settling and interrupt timing to the exact edge.

// File: rtl/svmon_pkg.sv
// Package: shared constants and helpers for the supply-monitor controller.
// Assumes byte offsets fit in the top's ADDR_W.
package svmon_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE553;
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_STAT  = 'h04;
    localparam int OFS_CLR   = 'h08;
    localparam int OFS_KEY   = 'h0C;
    localparam int OFS_READY = 'h10;

    // True for the threshold codes that software may program.
    function automatic logic thr_code_ok(input logic [3:0] c);
        return (c <= 4'd4) || (c == 4'd7) || (c == 4'd8) || (c == 4'd9);
    endfunction
endpackage

// File: rtl/svmon_sync.sv
// svmon_sync: multi-flop synchronizer for a slow asynchronous level.
// Assumes the input holds each level for several clock cycles.
module svmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the async level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/svmon_stab.sv
// svmon_stab: settling-wait counter that raises ready after STAB_CYC
// counted cycles. Counts only while enabled and while tick is high.
// Assumes restart is a one-cycle pulse from an accepted control write.
module svmon_stab #(
    parameter int STAB_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic restart,
    output logic ready
);
    localparam int CNT_W = $clog2(STAB_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYC - 1);

    logic [CNT_W-1:0] count;

    // Count enabled ticks until settling ends; restart or disable clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ready <= 1'b0;
        end else if (restart || !en) begin
            count <= '0;
            ready <= 1'b0;
        end else if (tick && !ready) begin
            count <= count + CNT_W'(1);
            if (count == LAST) ready <= 1'b1;
        end
    end

    // R9: a gated clock enable freezes the settling progress.
    p_gate_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart && en) |=> ($stable(count) && $stable(ready)));
    // R11: ready is never set while the enable is off.
    p_ready_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> en);
    // R5: ready rises only on a counted tick.
    p_ready_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tick));
endmodule

// File: rtl/svmon_regs.sv
// svmon_regs: register file, unlock key, and sticky interrupt flag.
// Assumes single-cycle write strobes and a synchronized comparator level.
module svmon_regs
    import svmon_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ready,
    input  logic              below_s,
    output logic              en,
    output logic [3:0]        thr,
    output logic              restart,
    output logic              flag
);
    logic unlocked;
    logic trig_q;
    logic wr_ctrl, wr_clr, wr_key, accept, trig;
    logic [3:0] new_thr;

    assign new_thr = bus_wdata[5:2];
    assign wr_ctrl = bus_wen && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_clr  = bus_wen && (bus_addr == ADDR_W'(OFS_CLR));
    assign wr_key  = bus_wen && (bus_addr == ADDR_W'(OFS_KEY));
    assign accept  = wr_ctrl && unlocked && thr_code_ok(new_thr);
    assign restart = accept && (!bus_wdata[7] || !en || (new_thr != thr));
    assign trig    = en && ready && below_s;

    // Track the lock state from key-register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked <= 1'b0;
        else if (wr_key) unlocked <= (bus_wdata == UNLOCK_KEY);
    end

    // Update enable and threshold on accepted control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            thr <= 4'd0;
        end else if (accept) begin
            en  <= bus_wdata[7];
            thr <= new_thr;
        end
    end

    // Sticky flag: set on a rising trigger, cleared by a zero clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig;
            if (wr_clr && !bus_wdata[0]) flag <= 1'b0;
            else if (trig && !trig_q)    flag <= 1'b1;
        end
    end

    // Read mux; unmapped offsets and the key register read 0.
    always_comb begin
        bus_rdata = 32'd0;
        if (bus_addr == ADDR_W'(OFS_CTRL))       bus_rdata[7:0] = {en, 1'b1, thr, 2'b00};
        else if (bus_addr == ADDR_W'(OFS_STAT))  bus_rdata[7]   = flag;
        else if (bus_addr == ADDR_W'(OFS_READY)) bus_rdata[0]   = ready;
    end

    // R1: a locked control write changes nothing.
    p_locked_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !unlocked) |=> ($stable(en) && $stable(thr)));
    // R3: an illegal code is refused.
    p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !thr_code_ok(new_thr)) |=> ($stable(en) && $stable(thr)));
    // R3: the stored code is always a legal one.
    p_thr_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        thr_code_ok(thr));
    // R4: the flag cannot rise while disabled.
    p_no_flag_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(flag));
    // R8: a zero clear bit always drops the flag.
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !bus_wdata[0]) |=> !flag);
endmodule

// File: rtl/svmon_top.sv
// svmon_top: supply-monitor interrupt controller. Connects the register
// file, settling counter and comparator synchronizer.
// Assumes cmp_below is a slow asynchronous level from the comparator.
module svmon_top #(
    parameter int ADDR_W      = 8,
    parameter int STAB_CYC    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cmp_below,
    output logic [3:0]        thr_sel,
    output logic              irq
);
    logic below_s, ready, en, restart;

    svmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_below), .q(below_s)
    );

    svmon_stab #(.STAB_CYC(STAB_CYC)) u_stab (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(pclk_en),
        .restart(restart), .ready(ready)
    );

    svmon_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready),
        .below_s(below_s), .en(en), .thr(thr_sel), .restart(restart),
        .flag(irq)
    );
endmodule

// File: tb/svmon_top_test.sv
`timescale 1ns/1ps
// Directed bench for svmon_top: one task per scenario.
module svmon_top_test;
    localparam int STAB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk_en = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        cmp_below = 1'b0;
    logic [3:0]  thr_sel;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    svmon_top #(.ADDR_W(8), .STAB_CYC(STAB), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_below(cmp_below), .thr_sel(thr_sel), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); chk("R2 reset ctrl", d, 32'h40);
        rd(8'h04, d); chk("R7 reset status", d, 32'h0);
        rd(8'h10, d); chk("R5 reset ready", d, 32'h0);
        rd(8'h0C, d); chk("R10 key reads 0", d, 32'h0);
        rd(8'h20, d); chk("R10 unmapped reads 0", d, 32'h0);
        chk("R7 reset irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(8'h00, 32'h9C);
        rd(8'h00, d); chk("R1 locked write ignored", d, 32'h40);
        wr(8'h0C, 32'h1ACCE553);
        wr(8'h00, 32'h1F);
        rd(8'h00, d); chk("R2 reserved bits and code", d, 32'h5C);
        chk("R2 thr_sel driven", {28'd0, thr_sel}, 32'h7);
        wr(8'h0C, 32'h0);
        wr(8'h00, 32'h04);
        rd(8'h00, d); chk("R1 relocked write ignored", d, 32'h5C);
    endtask

    task automatic t_badcode();
        logic [31:0] d;
        wr(8'h0C, 32'h1ACCE553);
        wr(8'h00, 32'h94);
        rd(8'h00, d); chk("R3 code 5 refused", d, 32'h5C);
        wr(8'h00, 32'hA8);
        rd(8'h00, d); chk("R3 code 10 refused", d, 32'h5C);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        cmp_below = 1'b1;
        wait_cyc(20);
        chk("R4 no irq while disabled", {31'd0, irq}, 32'h0);
        rd(8'h04, d); chk("R4 status clear while disabled", d, 32'h0);
        cmp_below = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_stab();
        logic [31:0] d;
        wr(8'h00, 32'h9C);
        wait_cyc(STAB - 1);
        rd(8'h10, d); chk("R5 not ready one cycle early", d, 32'h0);
        wait_cyc(1);
        rd(8'h10, d); chk("R5 ready after settling", d, 32'h1);
    endtask

    task automatic t_thr_change();
        logic [31:0] d;
        wr(8'h00, 32'hA0);
        rd(8'h10, d); chk("R6 code change drops ready", d, 32'h0);
        wait_cyc(STAB - 1);
        rd(8'h10, d); chk("R6 still settling", d, 32'h0);
        wait_cyc(1);
        rd(8'h10, d); chk("R6 ready again", d, 32'h1);
        wr(8'h00, 32'hA0);
        rd(8'h10, d); chk("R6 same code keeps ready", d, 32'h1);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        cmp_below = 1'b1;
        wait_cyc(2);
        chk("R12 irq not before third edge", {31'd0, irq}, 32'h0);
        wait_cyc(1);
        chk("R12 irq on third edge", {31'd0, irq}, 32'h1);
        rd(8'h04, d); chk("R7 status flag bit 7", d, 32'h80);
    endtask

    task automatic t_clear();
        wr(8'h08, 32'h1);
        chk("R8 clear bit 1 no effect", {31'd0, irq}, 32'h1);
        wr(8'h08, 32'h0);
        chk("R8 clear wins", {31'd0, irq}, 32'h0);
        wait_cyc(10);
        chk("R8 stays clear while low", {31'd0, irq}, 32'h0);
        cmp_below = 1'b0;
        wait_cyc(5);
        cmp_below = 1'b1;
        wait_cyc(3);
        chk("R7 new event sets flag", {31'd0, irq}, 32'h1);
        cmp_below = 1'b0;
        wr(8'h08, 32'h0);
        chk("R8 cleared again", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        wr(8'h00, 32'h20);
        rd(8'h10, d); chk("R11 disable drops ready", d, 32'h0);
        rd(8'h00, d); chk("R11 ctrl disabled", d, 32'h60);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        pclk_en = 1'b0;
        wr(8'h00, 32'h9C);
        wait_cyc(STAB + 10);
        rd(8'h10, d); chk("R9 gated wait stalls", d, 32'h0);
        pclk_en = 1'b1;
        wait_cyc(STAB - 1);
        rd(8'h10, d); chk("R9 resumed not yet ready", d, 32'h0);
        wait_cyc(1);
        rd(8'h10, d); chk("R9 ready after resumed count", d, 32'h1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_lock();
        t_badcode();
        t_disabled();
        t_stab();
        t_thr_change();
        t_irq();
        t_clear();
        t_disable();
        t_gate();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule